// File: doc/BRIEF.md
# Output Buffer Burst Flow Controller

This block regulates traffic through a 1024 x 32 output buffer that lies between a memory-side producer and a host-side DMA reader. It does not hold the data itself. It follows the buffer's word count from the producer's write strobe and the reader's read strobe. From that count it drives three active-low occupancy flags and a sticky overflow error.

On the producer side it asks for a refill burst of a fixed 256 words whenever the buffer has room for a whole burst. Once the producer accepts, no further request is raised until that burst's 256 words have arrived. On the reader side it grants permission to start a DMA burst only when at least half the buffer is filled, so the reader cannot starve mid-burst. When the retrieve channel reports that all requested data has been delivered, the half-full rule is waived so the last partial block can drain. The grant is only re-evaluated between reader bursts.

Top module: `outfifo_flow_ctrl`

## Requirements
- R1: `empty_n` is 0 exactly when the tracked word count is 0, updated on the clock edge that samples the strobe changing the count.
- R2: `half_n` is 0 exactly when the count is 512 or more, with the same timing as R1.
- R3: `full_n` is 0 exactly when the count is 1024. A write strobe at 1024 words is ignored and leaves the count at 1024.
- R4: A read strobe at 0 words is ignored and leaves the count at 0. A write strobe and a read strobe in the same cycle leave the count unchanged.
- R5: `err_flag` is set on the edge at which the count becomes 1024. It stays set after the count falls again.
- R6: A one-cycle `err_clr` pulse (the write-one-to-clear strobe) clears `err_flag` on the next edge. If the count becomes 1024 in that same cycle, setting wins.
- R7: With no refill outstanding, `fill_req` rises on the edge at which the free space (1024 minus count) is 256 or more. It stays high until accepted.
- R8: `fill_ack` sampled while `fill_req` is high drops `fill_req` on that edge. `fill_req` stays low until 256 accepted write strobes have been counted. After that, R7 decides again on the following edge.
- R9: Outside a reader burst, `rd_ok` is 1 on the edge after the count is 512 or more, and 0 when it is below 512 (with `retrieve_done` low).
- R10: Outside a reader burst, with `retrieve_done` high, `rd_ok` is 1 whenever the count is non-zero, even below 512. It is 0 at a count of 0.
- R11: From the edge that samples `rd_start` through the edge that samples `rd_end`, `rd_ok` keeps its value. It is re-evaluated from the edge after `rd_end`.
- R12: While `rst` is high, all outputs return on the next edge to `empty_n`=0, `half_n`=1, `full_n`=1, `err_flag`=0, `fill_req`=0, `rd_ok`=0, with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | A word is written into the buffer this cycle |
| pop | input | 1 | A word is read out of the buffer this cycle |
| fill_ack | input | 1 | Producer accepts the pending refill request |
| rd_start | input | 1 | Reader begins a DMA burst this cycle |
| rd_end | input | 1 | Reader finishes its DMA burst this cycle |
| retrieve_done | input | 1 | All requested data has been delivered into the buffer |
| err_clr | input | 1 | Write-one-to-clear strobe for the overflow error |
| fill_req | output | 1 | Request for one 256-word refill burst |
| rd_ok | output | 1 | Reader may start a DMA burst |
| empty_n | output | 1 | Active-low empty flag |
| half_n | output | 1 | Active-low half-full flag |
| full_n | output | 1 | Active-low full flag |
| err_flag | output | 1 | Sticky overflow error |

## Verification
Every output is a register fed from the count as it will be after the current edge. Each result is therefore due exactly one edge after the strobe that causes it: flags, error, request and grant alike. The one exception is `rd_ok`, which inside a reader burst is due only one edge after `rd_end`. The bench drives all inputs 1 ns after a rising edge and updates its prediction for the coming edge from those inputs. It compares every output 1 ns after that edge, so each check lands in the cycle the requirement names. Directed runs cover the exact count boundaries (0, 512, 1024 and one beyond), the clear-versus-set collision and the 256th refill word. A seeded random phase then mixes overlapping refill and reader bursts.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE  = 2'd0,
    FILL_REQ   = 2'd1,
    FILL_BURST = 2'd2
  } fill_state_e;
endpackage

// File: rtl/ofc_level_track.sv
module ofc_level_track #(
  parameter int DEPTH = 1024,
  parameter int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] lvl_d,
  output logic             acc_push,
  output logic             empty_n,
  output logic             half_n,
  output logic             full_n
);
  localparam logic [LVL_W-1:0] FULL_CNT = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] HALF_CNT = LVL_W'(DEPTH / 2);

  logic [LVL_W-1:0] lvl_q;
  logic             acc_pop;

  always_comb begin
    acc_push = push && (lvl_q != FULL_CNT);
    acc_pop  = pop && (lvl_q != '0);
    lvl_d    = lvl_q;
    if (acc_push && !acc_pop)
      lvl_d = lvl_q + LVL_W'(1);
    else if (!acc_push && acc_pop)
      lvl_d = lvl_q - LVL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      empty_n <= 1'b0;
      half_n  <= 1'b1;
      full_n  <= 1'b1;
    end else begin
      lvl_q   <= lvl_d;
      empty_n <= (lvl_d != '0);
      half_n  <= (lvl_d < HALF_CNT);
      full_n  <= (lvl_d != FULL_CNT);
    end
  end
endmodule

// File: rtl/ofc_err_latch.sv
module ofc_err_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  always_ff @(posedge clk) begin
    if (rst)
      err_o <= 1'b0;
    else if (set_i)
      err_o <= 1'b1;
    else if (clr_i)
      err_o <= 1'b0;
  end
endmodule

// File: rtl/ofc_refill_fsm.sv
module ofc_refill_fsm
  import ofc_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int BURST  = 256,
  parameter int LVL_W  = $clog2(DEPTH) + 1,
  parameter int BCNT_W = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] lvl_d,
  input  logic             acc_push,
  input  logic             fill_ack,
  output logic             fill_req
);
  localparam logic [LVL_W-1:0]  FULL_CNT  = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0]  BURST_CNT = LVL_W'(BURST);
  localparam logic [BCNT_W-1:0] LAST_WORD = BCNT_W'(BURST - 1);

  fill_state_e       st_q, st_d;
  logic [BCNT_W-1:0] cnt_q, cnt_d;
  logic [LVL_W-1:0]  free_words;

  assign free_words = FULL_CNT - lvl_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      FILL_IDLE:
        if (free_words >= BURST_CNT) st_d = FILL_REQ;
      FILL_REQ:
        if (fill_ack) begin
          st_d  = FILL_BURST;
          cnt_d = '0;
        end
      FILL_BURST:
        if (acc_push) begin
          if (cnt_q == LAST_WORD) st_d = FILL_IDLE;
          else                    cnt_d = cnt_q + BCNT_W'(1);
        end
      default: st_d = FILL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= FILL_IDLE;
      cnt_q    <= '0;
      fill_req <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      fill_req <= (st_d == FILL_REQ);
    end
  end
endmodule

// File: rtl/ofc_read_gate.sv
module ofc_read_gate #(
  parameter int DEPTH = 1024,
  parameter int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] lvl_d,
  input  logic             retrieve_done,
  input  logic             rd_start,
  input  logic             rd_end,
  output logic             rd_ok
);
  localparam logic [LVL_W-1:0] HALF_CNT = LVL_W'(DEPTH / 2);

  logic busy_q;
  logic grant;

  assign grant = (lvl_d >= HALF_CNT) || (retrieve_done && (lvl_d != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rd_ok  <= 1'b0;
    end else begin
      if (!busy_q && !rd_start)
        rd_ok <= grant;
      if (rd_start)
        busy_q <= 1'b1;
      else if (rd_end)
        busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/outfifo_flow_ctrl.sv
module outfifo_flow_ctrl #(
  parameter int DEPTH = 1024,
  parameter int BURST = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic fill_ack,
  input  logic rd_start,
  input  logic rd_end,
  input  logic retrieve_done,
  input  logic err_clr,
  output logic fill_req,
  output logic rd_ok,
  output logic empty_n,
  output logic half_n,
  output logic full_n,
  output logic err_flag
);
  localparam int LVL_W = $clog2(DEPTH) + 1;
  localparam logic [LVL_W-1:0] FULL_CNT = LVL_W'(DEPTH);

  logic [LVL_W-1:0] lvl_d;
  logic             acc_push;

  ofc_level_track #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .lvl_d(lvl_d), .acc_push(acc_push),
    .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
  );

  ofc_err_latch u_err (
    .clk(clk), .rst(rst),
    .set_i(lvl_d == FULL_CNT), .clr_i(err_clr), .err_o(err_flag)
  );

  ofc_refill_fsm #(.DEPTH(DEPTH), .BURST(BURST), .LVL_W(LVL_W)) u_refill (
    .clk(clk), .rst(rst), .lvl_d(lvl_d), .acc_push(acc_push),
    .fill_ack(fill_ack), .fill_req(fill_req)
  );

  ofc_read_gate #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_gate (
    .clk(clk), .rst(rst), .lvl_d(lvl_d), .retrieve_done(retrieve_done),
    .rd_start(rd_start), .rd_end(rd_end), .rd_ok(rd_ok)
  );
endmodule

// File: rtl/ofc_checker.sv
module ofc_checker (
  input logic clk,
  input logic rst,
  input logic push,
  input logic pop,
  input logic fill_ack,
  input logic fill_req,
  input logic rd_start,
  input logic rd_ok,
  input logic err_clr,
  input logic err_flag,
  input logic empty_n,
  input logic half_n,
  input logic full_n
);
  assert_empty_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !empty_n |-> (half_n && full_n));

  assert_full_implies_half_R3: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> !half_n);

  assert_pop_empty_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && pop && !push) |=> !empty_n);

  assert_full_sets_err_R5: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> err_flag);

  assert_err_fall_needs_clr_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(err_flag) |-> $past(err_clr));

  assert_ack_drops_req_R8: assert property (@(posedge clk) disable iff (rst)
    (fill_req && fill_ack) |=> !fill_req);

  assert_grant_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> $stable(rd_ok));
endmodule

bind outfifo_flow_ctrl ofc_checker u_ofc_checker (
  .clk(clk), .rst(rst), .push(push), .pop(pop),
  .fill_ack(fill_ack), .fill_req(fill_req),
  .rd_start(rd_start), .rd_ok(rd_ok),
  .err_clr(err_clr), .err_flag(err_flag),
  .empty_n(empty_n), .half_n(half_n), .full_n(full_n)
);

// File: tb/tb_outfifo_flow_ctrl.sv
`timescale 1ns/1ps
module tb_outfifo_flow_ctrl;
  localparam int DEPTH = 1024;
  localparam int BURST = 256;
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, push, pop, fill_ack, rd_start, rd_end, retrieve_done, err_clr;
  logic fill_req, rd_ok, empty_n, half_n, full_n, err_flag;

  outfifo_flow_ctrl #(.DEPTH(DEPTH), .BURST(BURST)) dut (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .fill_ack(fill_ack),
    .rd_start(rd_start), .rd_end(rd_end), .retrieve_done(retrieve_done),
    .err_clr(err_clr), .fill_req(fill_req), .rd_ok(rd_ok),
    .empty_n(empty_n), .half_n(half_n), .full_n(full_n), .err_flag(err_flag)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // prediction state
  int m_lvl = 0;
  int m_st  = 0;   // 0 idle, 1 request pending, 2 refill in flight
  int m_cnt = 0;
  bit m_err = 0, m_busy = 0, m_rdok = 0;

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit grant_rule(int lvl, bit done);
    return (lvl >= HALF) || (done && lvl != 0);
  endfunction

  task automatic clear_inputs();
    push = 0; pop = 0; fill_ack = 0; rd_start = 0; rd_end = 0; err_clr = 0;
  endtask

  task automatic cycle();
    bit ap, ao;
    int nl;
    ap = push && (m_lvl != DEPTH);
    ao = pop && (m_lvl != 0);
    nl = m_lvl + (ap ? 1 : 0) - (ao ? 1 : 0);
    m_err = (nl == DEPTH) ? 1'b1 : (err_clr ? 1'b0 : m_err);
    case (m_st)
      0: if (DEPTH - nl >= BURST) m_st = 1;
      1: if (fill_ack) begin m_st = 2; m_cnt = 0; end
      default: if (ap) begin
        if (m_cnt == BURST - 1) m_st = 0; else m_cnt++;
      end
    endcase
    if (!m_busy && !rd_start) m_rdok = grant_rule(nl, retrieve_done);
    m_busy = rd_start ? 1'b1 : (rd_end ? 1'b0 : m_busy);
    m_lvl = nl;
    @(posedge clk);
    #1;
    chk("R1 empty_n", empty_n, m_lvl != 0);
    chk("R2 half_n", half_n, m_lvl < HALF);
    chk("R3 full_n", full_n, m_lvl != DEPTH);
    chk("R5/R6 err_flag", err_flag, m_err);
    chk("R7/R8 fill_req", fill_req, m_st == 1);
    chk("R9/R10/R11 rd_ok", rd_ok, m_rdok);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prod_left, clen;
    bit cb;
    void'($urandom(32'd20240611));
    clear_inputs();
    retrieve_done = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset values
    chk("R12 empty_n", empty_n, 1'b0);
    chk("R12 half_n", half_n, 1'b1);
    chk("R12 full_n", full_n, 1'b1);
    chk("R12 err_flag", err_flag, 1'b0);
    chk("R12 fill_req", fill_req, 1'b0);
    chk("R12 rd_ok", rd_ok, 1'b0);
    rst = 0;

    // R7: empty buffer has room, request rises after first edge
    cycle();
    chk("R7 request on empty", fill_req, 1'b1);

    // fill to exactly full without acknowledging (R2, R3, R5)
    push = 1;
    run(DEPTH);
    chk("R3 full at 1024", full_n, 1'b0);
    chk("R5 err set at full", err_flag, 1'b1);
    chk("R9 grant above half", rd_ok, 1'b1);
    run(1);                       // extra write while full
    push = 0; pop = 1; run(1);
    chk("R3 one read after ignored write leaves not full", full_n, 1'b1);
    pop = 0; push = 1; run(1);
    chk("R3 count was 1023, one write is full again", full_n, 1'b0);
    push = 0; pop = 1; run(10);
    chk("R5 err sticky below full", err_flag, 1'b1);
    pop = 0; err_clr = 1; run(1);
    chk("R6 err cleared", err_flag, 1'b0);
    err_clr = 0; push = 1; run(9);
    err_clr = 1; run(1);
    chk("R6 set wins over clear", err_flag, 1'b1);
    clear_inputs();

    // R11: grant frozen inside a reader burst
    rd_start = 1; run(1);
    rd_start = 0; pop = 1; run(700);
    chk("R11 grant held while count fell below half", rd_ok, 1'b1);
    pop = 0; rd_end = 1; run(1);
    rd_end = 0; run(1);
    chk("R9 grant dropped below half after burst", rd_ok, 1'b0);
    retrieve_done = 1; run(1);
    chk("R10 retrieve done waives half", rd_ok, 1'b1);
    pop = 1; run(DEPTH - 700);
    chk("R10 no grant at zero", rd_ok, 1'b0);
    run(1);                       // read while empty
    pop = 0; push = 1; run(1);
    chk("R4 read at empty ignored", empty_n, 1'b1);
    push = 1; pop = 1; run(1);
    chk("R4 simultaneous strobes keep count", empty_n, 1'b1);
    clear_inputs();
    retrieve_done = 0;

    // R8: acknowledged refill
    chk("R7 request pending before ack", fill_req, 1'b1);
    fill_ack = 1; run(1);
    chk("R8 ack drops request", fill_req, 1'b0);
    fill_ack = 0; push = 1; run(BURST - 1);
    chk("R8 still low before last word", fill_req, 1'b0);
    run(1);
    chk("R8 low on last-word edge", fill_req, 1'b0);
    push = 0; run(1);
    chk("R8 request re-raised after burst", fill_req, 1'b1);

    // seeded random mix of refill and reader bursts
    prod_left = 0; cb = 0; clen = 0;
    for (int i = 0; i < 6000; i++) begin
      clear_inputs();
      retrieve_done = (i > 3000) && ((i % 600) < 300);
      if (fill_req && prod_left == 0) begin
        fill_ack = 1;
        prod_left = BURST;
      end else if (prod_left > 0 && ($urandom % 4) != 0) begin
        push = 1;
        prod_left--;
      end
      if (!cb && rd_ok && ($urandom % 8) == 0) begin
        rd_start = 1;
        cb = 1;
        clen = 1 + ($urandom % 300);
      end else if (cb) begin
        if (clen == 0) begin
          rd_end = 1;
          cb = 0;
        end else begin
          pop = (($urandom % 4) != 0);
          clen--;
        end
      end
      err_clr = (($urandom % 64) == 0);
      cycle();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule